// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out where a load or store goes and what the base register holds once the access is done. It takes a base value, an offset and a mode. The base is either a register value or the program counter. The offset is a zero-extended immediate, a register value, or a register value passed through a barrel shifter. The mode selects one of three indexing modes: plain offset, pre-indexed or post-indexed. The offset is added to or subtracted from the base. All sums wrap modulo 2^DATA_W and no flag is produced.

The effective address and the writeback value are selected separately. When the program counter is the base, the block adds the pipeline lookahead for the current instruction width before any other arithmetic. The block is combinational. Setting `OUT_REG` to 1 adds one register stage on the results, and `out_valid` then follows `in_valid` by one cycle.

Top module: `agu_top`

## Requirements
- R1: With `mode` = 0 (plain offset), `eff_addr` = base ± offset, `wb_val` equals the base, and `wb_en` = 0.
- R2: With `mode` = 1 (pre-indexed), `eff_addr` and `wb_val` both equal base ± offset, and `wb_en` = 1.
- R3: With `mode` = 2 (post-indexed), `eff_addr` equals the unmodified base, `wb_val` = base ± offset, and `wb_en` = 1.
- R4: `off_form` selects the offset: 0 = `imm_off` zero-extended, 1 = `idx_val` unchanged, 2 = `idx_val` after the barrel shifter, 3 = zero offset.
- R5: `add_dir` = 1 adds the offset and `add_dir` = 0 subtracts it. Both results wrap modulo 2^32 and no carry or overflow is reported.
- R6: `sh_type` selects the shift applied in form 2: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The 5-bit `sh_amt` gives the distance.
- R7: A shift amount of 0 passes `idx_val` through unchanged for every shift type.
- R8: With `base_is_pc` = 1, the base is `pc_val` + 8 when `narrow_isa` = 0 and `pc_val` + 4 when `narrow_isa` = 1. Otherwise the base is `base_val`.
- R9: `mode` = 3 behaves exactly like plain offset mode.
- R10: With `OUT_REG` = 1, each result appears one cycle after its `in_valid` cycle with `out_valid` = 1. Reset clears `out_valid` and all result outputs to 0. With `OUT_REG` = 0, the outputs follow the inputs in the same cycle.
- R11: These two cases must give the stated results:
  - Scaled form, logical left by 2, base 0x1009C, index 3: address 0x100A8.
  - Post-indexed register form, base 0x1009F, offset 3: address 0x1009F and writeback 0x100A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| base_val | input | DATA_W | Base register value |
| base_is_pc | input | 1 | Use the adjusted program counter as the base |
| pc_val | input | DATA_W | Address of the current instruction |
| narrow_isa | input | 1 | 1 = 16-bit instruction state, 0 = 32-bit state |
| off_form | input | 2 | Offset source selector |
| imm_off | input | IMM_W | Immediate offset |
| idx_val | input | DATA_W | Index register value |
| sh_type | input | 2 | Shift type for the scaled form |
| sh_amt | input | SHAMT_W | Shift distance |
| add_dir | input | 1 | 1 = add the offset, 0 = subtract it |
| mode | input | 2 | Indexing mode |
| out_valid | output | 1 | Result valid |
| eff_addr | output | DATA_W | Effective memory address |
| wb_val | output | DATA_W | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |

## Verification
The bench builds two instances with DATA_W = 32, IMM_W = 12 and SHAMT_W = 5. The first uses OUT_REG = 1 and is checked through a queue that is popped whenever `out_valid` rises. The second uses OUT_REG = 0 and is checked in the same cycle. Running both covers the register stage's latency and reset clearing, as well as the purely combinational variant. With a 32-bit datapath, the full 5-bit shift range, subtraction below zero and carries past 2^32 can all be reached.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      FORM_IMM    = 2'd0,
      FORM_REG    = 2'd1,
      FORM_SCALED = 2'd2,
      FORM_NONE   = 2'd3
   } off_form_e;

   typedef enum logic [1:0] {
      MODE_OFFSET = 2'd0,
      MODE_PRE    = 2'd1,
      MODE_POST   = 2'd2,
      MODE_RSVD   = 2'd3
   } idx_mode_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_e;

endpackage

// File: rtl/agu_pc_adjust.sv
module agu_pc_adjust #(
   parameter int DATA_W      = 32,
   parameter int WIDE_STEP   = 8,
   parameter int NARROW_STEP = 4
) (
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] pc_val,
   input  logic              base_is_pc,
   input  logic              narrow_isa,
   output logic [DATA_W-1:0] base_eff
);
   localparam logic [DATA_W-1:0] WIDE_INC   = DATA_W'(WIDE_STEP);
   localparam logic [DATA_W-1:0] NARROW_INC = DATA_W'(NARROW_STEP);

   generate
      if (WIDE_STEP <= 0 || NARROW_STEP <= 0) begin : g_bad_step
         $error("agu_pc_adjust: lookahead steps must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] pc_inc;

   always_comb begin
      pc_inc   = narrow_isa ? NARROW_INC : WIDE_INC;
      base_eff = base_is_pc ? (pc_val + pc_inc) : base_val;
   end
endmodule

// File: rtl/agu_shifter.sv
module agu_shifter
   import agu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input  logic [DATA_W-1:0]  din,
   input  shift_e             sh_type,
   input  logic [SHAMT_W-1:0] sh_amt,
   output logic [DATA_W-1:0]  dout
);
   generate
      if ((1 << SHAMT_W) != DATA_W) begin : g_bad_width
         $error("agu_shifter: DATA_W must equal 2**SHAMT_W");
      end
   endgenerate

   // Logarithmic shifter: stage i moves the word by 2**i when sh_amt[i] is set.
   logic [DATA_W-1:0] stg [0:SHAMT_W];

   assign stg[0] = din;

   genvar i;
   generate
      for (i = 0; i < SHAMT_W; i++) begin : g_stage
         localparam int K = 1 << i;
         logic [DATA_W-1:0] moved;
         always_comb begin
            unique case (sh_type)
               SH_LSL:  moved = {stg[i][DATA_W-K-1:0], {K{1'b0}}};
               SH_LSR:  moved = {{K{1'b0}}, stg[i][DATA_W-1:K]};
               SH_ASR:  moved = {{K{stg[i][DATA_W-1]}}, stg[i][DATA_W-1:K]};
               default: moved = {stg[i][K-1:0], stg[i][DATA_W-1:K]};
            endcase
         end
         assign stg[i+1] = sh_amt[i] ? moved : stg[i];
      end
   endgenerate

   assign dout = stg[SHAMT_W];
endmodule

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
   import agu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 12
) (
   input  off_form_e         form,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic [DATA_W-1:0] idx_val,
   input  logic [DATA_W-1:0] idx_shifted,
   output logic [DATA_W-1:0] offset
);
   localparam int PAD_W = DATA_W - IMM_W;

   generate
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("agu_offset_sel: IMM_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm_off};
      end else begin : g_nopad
         assign imm_ext = imm_off;
      end
   endgenerate

   always_comb begin
      unique case (form)
         FORM_IMM:    offset = imm_ext;
         FORM_REG:    offset = idx_val;
         FORM_SCALED: offset = idx_shifted;
         default:     offset = '0;
      endcase
   end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
   import agu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] offset,
   input  logic              add_dir,
   input  idx_mode_e         mode,
   output logic [DATA_W-1:0] eff_addr,
   output logic [DATA_W-1:0] wb_val,
   output logic              wb_en
);
   logic [DATA_W-1:0] moved;

   always_comb begin
      moved = add_dir ? (base + offset) : (base - offset);
      unique case (mode)
         MODE_PRE: begin
            eff_addr = moved;
            wb_val   = moved;
            wb_en    = 1'b1;
         end
         MODE_POST: begin
            eff_addr = base;
            wb_val   = moved;
            wb_en    = 1'b1;
         end
         default: begin
            eff_addr = moved;
            wb_val   = base;
            wb_en    = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/agu_top.sv
module agu_top
   import agu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IMM_W       = 12,
   parameter int SHAMT_W     = 5,
   parameter int WIDE_STEP   = 8,
   parameter int NARROW_STEP = 4,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  base_val,
   input  logic               base_is_pc,
   input  logic [DATA_W-1:0]  pc_val,
   input  logic               narrow_isa,
   input  logic [1:0]         off_form,
   input  logic [IMM_W-1:0]   imm_off,
   input  logic [DATA_W-1:0]  idx_val,
   input  logic [1:0]         sh_type,
   input  logic [SHAMT_W-1:0] sh_amt,
   input  logic               add_dir,
   input  logic [1:0]         mode,
   output logic               out_valid,
   output logic [DATA_W-1:0]  eff_addr,
   output logic [DATA_W-1:0]  wb_val,
   output logic               wb_en
);
   localparam logic [DATA_W-1:0] WIDE_INC   = DATA_W'(WIDE_STEP);
   localparam logic [DATA_W-1:0] NARROW_INC = DATA_W'(NARROW_STEP);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("agu_top: DATA_W too small");
      end
   endgenerate

   off_form_e form_e;
   idx_mode_e mode_e;
   shift_e    shift_sel;

   assign form_e    = off_form_e'(off_form);
   assign mode_e    = idx_mode_e'(mode);
   assign shift_sel = shift_e'(sh_type);

   logic [DATA_W-1:0] base_eff;
   logic [DATA_W-1:0] idx_shifted;
   logic [DATA_W-1:0] offset;
   logic [DATA_W-1:0] c_addr;
   logic [DATA_W-1:0] c_wb;
   logic              c_wb_en;

   agu_pc_adjust #(
      .DATA_W     (DATA_W),
      .WIDE_STEP  (WIDE_STEP),
      .NARROW_STEP(NARROW_STEP)
   ) i_pc_adjust (
      .base_val  (base_val),
      .pc_val    (pc_val),
      .base_is_pc(base_is_pc),
      .narrow_isa(narrow_isa),
      .base_eff  (base_eff)
   );

   agu_shifter #(
      .DATA_W (DATA_W),
      .SHAMT_W(SHAMT_W)
   ) i_shifter (
      .din    (idx_val),
      .sh_type(shift_sel),
      .sh_amt (sh_amt),
      .dout   (idx_shifted)
   );

   agu_offset_sel #(
      .DATA_W(DATA_W),
      .IMM_W (IMM_W)
   ) i_offset_sel (
      .form       (form_e),
      .imm_off    (imm_off),
      .idx_val    (idx_val),
      .idx_shifted(idx_shifted),
      .offset     (offset)
   );

   agu_addr_calc #(
      .DATA_W(DATA_W)
   ) i_addr_calc (
      .base    (base_eff),
      .offset  (offset),
      .add_dir (add_dir),
      .mode    (mode_e),
      .eff_addr(c_addr),
      .wb_val  (c_wb),
      .wb_en   (c_wb_en)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               eff_addr  <= '0;
               wb_val    <= '0;
               wb_en     <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  eff_addr <= c_addr;
                  wb_val   <= c_wb;
                  wb_en    <= c_wb_en;
               end
            end
         end

         // R10: one-cycle latency of the valid flag
         a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_comb
         assign out_valid = in_valid;
         assign eff_addr  = c_addr;
         assign wb_val    = c_wb;
         assign wb_en     = c_wb_en;
      end
   endgenerate

   // R1 / R9: no writeback in plain offset or reserved mode
   a_r1_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode_e == MODE_OFFSET || mode_e == MODE_RSVD)) |-> (!c_wb_en && c_wb == base_eff));

   // R2: pre-indexed writes back the very address it used
   a_r2_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_e == MODE_PRE) |-> (c_wb_en && c_wb == c_addr));

   // R3: post-indexed uses the adjusted base as the address
   a_r3_post_base: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_e == MODE_POST) |-> (c_wb_en && c_addr == base_eff));

   // R7: zero shift distance leaves the index untouched
   a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sh_amt == '0) |-> (idx_shifted == idx_val));

   // R8: program counter lookahead
   a_r8_pc_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_is_pc && !narrow_isa) |-> (base_eff == pc_val + WIDE_INC));
   a_r8_pc_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_is_pc && narrow_isa) |-> (base_eff == pc_val + NARROW_INC));

   // R4: the zero form contributes nothing
   a_r4_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && form_e == FORM_NONE) |-> (offset == '0));
endmodule

// File: tb/test_agu_top.sv
`timescale 1ns/1ps
module test_agu_top;
   localparam int W  = 32;
   localparam int IW = 12;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  base_val = '0;
   logic          base_is_pc = 1'b0;
   logic [W-1:0]  pc_val = '0;
   logic          narrow_isa = 1'b0;
   logic [1:0]    off_form = '0;
   logic [IW-1:0] imm_off = '0;
   logic [W-1:0]  idx_val = '0;
   logic [1:0]    sh_type = '0;
   logic [SW-1:0] sh_amt = '0;
   logic          add_dir = 1'b1;
   logic [1:0]    mode = '0;

   logic          out_valid, c_valid;
   logic [W-1:0]  eff_addr, wb_val, c_addr, c_wb;
   logic          wb_en, c_wb_en;

   always #2 clk = ~clk;

   agu_top #(.DATA_W(W), .IMM_W(IW), .SHAMT_W(SW), .OUT_REG(1'b1)) i_agu_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
      .base_is_pc(base_is_pc), .pc_val(pc_val), .narrow_isa(narrow_isa),
      .off_form(off_form), .imm_off(imm_off), .idx_val(idx_val),
      .sh_type(sh_type), .sh_amt(sh_amt), .add_dir(add_dir), .mode(mode),
      .out_valid(out_valid), .eff_addr(eff_addr), .wb_val(wb_val), .wb_en(wb_en));

   agu_top #(.DATA_W(W), .IMM_W(IW), .SHAMT_W(SW), .OUT_REG(1'b0)) i_agu_top_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
      .base_is_pc(base_is_pc), .pc_val(pc_val), .narrow_isa(narrow_isa),
      .off_form(off_form), .imm_off(imm_off), .idx_val(idx_val),
      .sh_type(sh_type), .sh_amt(sh_amt), .add_dir(add_dir), .mode(mode),
      .out_valid(c_valid), .eff_addr(c_addr), .wb_val(c_wb), .wb_en(c_wb_en));

   typedef struct packed {
      logic [W-1:0] addr;
      logic [W-1:0] wb;
      logic         wbe;
      logic [7:0]   tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   task automatic chk(input int tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ref_shift(input logic [W-1:0] x, input logic [1:0] t, input logic [SW-1:0] a);
      logic [2*W-1:0] dbl;
      case (t)
         2'd0: return x << a;
         2'd1: return x >> a;
         2'd2: return W'($signed(x) >>> a);
         default: begin
            dbl = {x, x} >> a;
            return dbl[W-1:0];
         end
      endcase
   endfunction

   function automatic exp_t ref_model(input int tag);
      exp_t e;
      logic [W-1:0] b, off, s;
      b = base_is_pc ? (pc_val + (narrow_isa ? 32'd4 : 32'd8)) : base_val;
      case (off_form)
         2'd0: off = {{(W-IW){1'b0}}, imm_off};
         2'd1: off = idx_val;
         2'd2: off = ref_shift(idx_val, sh_type, sh_amt);
         default: off = '0;
      endcase
      s = add_dir ? b + off : b - off;
      e.tag = 8'(tag);
      case (mode)
         2'd1: begin e.addr = s; e.wb = s; e.wbe = 1'b1; end
         2'd2: begin e.addr = b; e.wb = s; e.wbe = 1'b1; end
         default: begin e.addr = s; e.wb = b; e.wbe = 1'b0; end
      endcase
      return e;
   endfunction

   // Driver: applies one request, queues its expectation, checks the combinational copy.
   task automatic drive(input logic [W-1:0] b, input logic ispc, input logic [W-1:0] pc,
                        input logic th, input logic [1:0] f, input logic [IW-1:0] im,
                        input logic [W-1:0] ix, input logic [1:0] st, input logic [SW-1:0] sa,
                        input logic ad, input logic [1:0] md, input int tag);
      exp_t e;
      @(negedge clk);
      base_val = b; base_is_pc = ispc; pc_val = pc; narrow_isa = th;
      off_form = f; imm_off = im; idx_val = ix; sh_type = st; sh_amt = sa;
      add_dir = ad; mode = md; in_valid = 1'b1;
      e = ref_model(tag);
      exp_q.push_back(e);
      #1;
      // R10: the unregistered variant answers in the same cycle
      chk(tag, "comb addr", c_addr, e.addr);
      chk(tag, "comb wb", c_wb, e.wb);
      chk(tag, "comb wb_en", {31'd0, c_wb_en}, {31'd0, e.wbe});
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: pops the oldest expectation whenever the registered copy delivers.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(10, "unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(e.tag), "addr", eff_addr, e.addr);
            chk(int'(e.tag), "wb", wb_val, e.wb);
            chk(int'(e.tag), "wb_en", {31'd0, wb_en}, {31'd0, e.wbe});
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R10 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(10, "reset out_valid", {31'd0, out_valid}, 32'd0);
      chk(10, "reset addr", eff_addr, 32'd0);
      chk(10, "reset wb", wb_val, 32'd0);
      chk(10, "reset wb_en", {31'd0, wb_en}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11: scaled left by 2, base 0x1009C, index 3 (form 2, type 0, mode 0)
      drive(32'h1009C, 0, 0, 0, 2'd2, 12'd0, 32'd3, 2'd0, 5'd2, 1, 2'd0, 11);
      chk(11, "scaled example addr", c_addr, 32'h100A8);
      // R11: post-indexed register form (form 1, mode 2)
      drive(32'h1009F, 0, 0, 0, 2'd1, 12'd0, 32'd3, 2'd0, 5'd0, 1, 2'd2, 11);
      chk(11, "post example addr", c_addr, 32'h1009F);
      chk(11, "post example wb", c_wb, 32'h100A2);
      // R2: pre-indexed immediate
      drive(32'h1009C, 0, 0, 0, 2'd0, 12'd4, 32'd0, 2'd0, 5'd0, 1, 2'd1, 2);
      chk(2, "pre imm addr", c_addr, 32'h100A0);
      // R1: plain offset immediate
      drive(32'h1009C, 0, 0, 0, 2'd0, 12'd2, 32'd0, 2'd0, 5'd0, 1, 2'd0, 1);
      chk(1, "offset wb_en", {31'd0, c_wb_en}, 32'd0);
      // R5: subtract below zero wraps
      drive(32'd4, 0, 0, 0, 2'd0, 12'd8, 32'd0, 2'd0, 5'd0, 0, 2'd1, 5);
      chk(5, "sub wrap", c_addr, 32'hFFFF_FFFC);
      // R5: add past the top wraps
      drive(32'hFFFF_FFF0, 0, 0, 0, 2'd1, 12'd0, 32'h20, 2'd0, 5'd0, 1, 2'd0, 5);
      chk(5, "add wrap", c_addr, 32'h10);
      // R8: program counter base in both states
      drive(32'hDEAD_BEEF, 1, 32'h8074, 0, 2'd0, 12'd12, 32'd0, 2'd0, 5'd0, 1, 2'd0, 8);
      chk(8, "pc wide", c_addr, 32'h8088);
      drive(32'hDEAD_BEEF, 1, 32'h8074, 1, 2'd0, 12'd12, 32'd0, 2'd0, 5'd0, 1, 2'd2, 8);
      chk(8, "pc narrow", c_addr, 32'h8078);
      // R4: zero-offset form
      drive(32'h1234_5678, 0, 0, 0, 2'd3, 12'hFFF, 32'hFFFF_FFFF, 2'd0, 5'd3, 1, 2'd1, 4);
      chk(4, "no offset", c_addr, 32'h1234_5678);
      // R6: arithmetic right keeps the sign
      drive(32'd0, 0, 0, 0, 2'd2, 12'd0, 32'h8000_0000, 2'd2, 5'd4, 1, 2'd0, 6);
      chk(6, "asr sign", c_addr, 32'hF800_0000);
      // R6: rotate right
      drive(32'd0, 0, 0, 0, 2'd2, 12'd0, 32'h0000_000F, 2'd3, 5'd4, 1, 2'd0, 6);
      chk(6, "ror", c_addr, 32'hF000_0000);
      // R9: reserved mode equals plain offset
      drive(32'h100, 0, 0, 0, 2'd0, 12'h10, 32'd0, 2'd0, 5'd0, 1, 2'd3, 9);
      chk(9, "rsvd mode addr", c_addr, 32'h110);
      chk(9, "rsvd mode wb", c_wb, 32'h100);
      idle();
      idle();
      // R10: valid drops one cycle after the request stops
      chk(10, "idle out_valid", {31'd0, out_valid}, 32'd0);

      // R7: zero shift distance for every type
      for (int t = 0; t < 4; t++)
         drive(32'h1000, 0, 0, 0, 2'd2, 12'd0, 32'h8765_4321, 2'(t), 5'd0, 1, 2'd0, 7);

      // R1 R2 R3 R9 with R4 R5 R6 crossed over forms, directions and shift types
      for (int md = 0; md < 4; md++)
         for (int f = 0; f < 4; f++)
            for (int t = 0; t < 4; t++)
               for (int ad = 0; ad < 2; ad++)
                  drive(W'($urandom), 1'($urandom), W'($urandom), 1'($urandom), 2'(f),
                        IW'($urandom), W'($urandom), 2'(t), SW'($urandom), 1'(ad), 2'(md),
                        (md == 0) ? 1 : (md == 1) ? 2 : (md == 2) ? 3 : 9);
      idle();

      // R6: random shifts with gaps in the request stream
      for (int k = 0; k < 200; k++) begin
         drive(W'($urandom), 1'($urandom), W'($urandom), 1'($urandom), 2'($urandom),
               IW'($urandom), W'($urandom), 2'($urandom), SW'($urandom), 1'($urandom),
               2'($urandom), 6);
         if (k % 7 == 0) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      chk(10, "queue drained", 32'(exp_q.size()), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule